// File: doc/BRIEF.md
# Time-Multiplexed Leaky Integrate-and-Fire Neuron Core

This block runs a bank of leaky integrate-and-fire neurons through one shared update circuit. Each neuron's state sits in a local memory word: its membrane potential, the step number of its most recent fire, and a flag that records whether it has ever fired. A strobe starts an algorithmic time step. The core then visits every neuron index in ascending order. For each one it reads the stored state, presents the index to an external weight source and takes back one signed weight per input line. It adds the weights of the input lines marked active for this step, removes a constant leak, decides whether the neuron fires, and writes the new state back.

Each neuron that fires is reported by its index on a valid/ready stream. The sweep waits while the consumer holds ready low. When the sweep has finished, a one-cycle done pulse is raised. Two reset behaviours are available after a fire: load a fixed value, or subtract a fixed amount. A refractory window, counted in steps since the neuron's last fire, blocks repeated firing. The potential saturates instead of wrapping, and the leak stops at a configurable floor.

Top module: `lif_neuron_core`

## Requirements
- R1: After reset, fire_valid and step_done are low. The core then clears every neuron over N_NEURONS cycles, leaving each potential at zero with no fire history, and ignores step_start during that time. In the first step after reset, with zero weights and zero leak, every neuron fires if cfg_threshold is -1 and none fires if it is 0.
- R2: For each neuron, the integrated potential is the stored potential plus the sum of the weights whose in_spike bit was latched high at the accepted step_start, minus cfg_leak. Input i's weight for the neuron at wt_addr is the two's-complement field wt_row[i*W_W +: W_W].
- R3: The potential is a POT_W-bit signed value. The sum of the old potential and the weights clamps at the largest and smallest representable values and never wraps.
- R4: The leak never carries the potential below cfg_floor. If removing cfg_leak would land below the floor, the result is the floor. A potential that the weights alone already placed below the floor keeps its value.
- R5: A neuron fires only when its potential is strictly greater than the signed cfg_threshold and, if it has fired before, the number of steps since its last fire (modulo 2^STEP_W) is strictly greater than cfg_refractory. Every accepted step_start advances the step number by one.
- R6: When a neuron fires, cfg_reset_mode 0 loads cfg_reset_val into its potential. cfg_reset_mode 1 subtracts the unsigned cfg_sub_amt from it, clamping at the smallest value.
- R7: Each firing neuron appears exactly once per step on fire_idx, in ascending index order. While fire_valid is high and fire_ready is low, the sweep stalls and fire_idx stays unchanged.
- R8: step_done is a single-cycle pulse. It rises the cycle after the last neuron has been written back and any fire of that neuron has been accepted, and it comes once per accepted step.
- R9: A step_start that arrives while a sweep is in progress has no effect. It adds no step number and produces no extra sweep or step_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_start | input | 1 | Starts a time step when the core is idle |
| in_spike | input | NUM_IN | Active input lines for the step, latched at step start |
| wt_addr | output | IDX_W | Neuron index whose weight row is requested |
| wt_row | input | NUM_IN*W_W | Signed weights of all inputs for neuron wt_addr |
| cfg_threshold | input | POT_W | Signed firing threshold |
| cfg_leak | input | POT_W | Unsigned leak removed each step |
| cfg_floor | input | POT_W | Signed lower limit for the leak |
| cfg_refractory | input | STEP_W | Refractory length in steps |
| cfg_reset_mode | input | 1 | 0: load reset value, 1: subtract amount |
| cfg_reset_val | input | POT_W | Signed potential loaded after a fire in mode 0 |
| cfg_sub_amt | input | POT_W | Unsigned amount subtracted after a fire in mode 1 |
| fire_valid | output | 1 | A fired index is offered |
| fire_ready | input | 1 | Consumer accepts the fired index |
| fire_idx | output | IDX_W | Index of the fired neuron |
| step_done | output | 1 | One-cycle pulse at the end of a sweep |

## Verification
The bench builds the core with eight neurons, four input lines, 8-bit weights, and 16-bit potentials and step numbers. With only eight neurons, a full sweep takes a couple of dozen cycles. That makes it affordable to drive potentials into both the upper saturation limit and the leak floor, and to walk a neuron through a complete refractory window. A reference model of the potentials, driven by the same weight function and configuration, predicts each step's fire list. The bench compares that list in order, under both a free-running consumer and a stalling one.

// File: rtl/lif_core_pkg.sv
`timescale 1ns/1ps
// Package: shared types of the neuron core.
// Holds the sweep controller state encoding used by the top module.
package lif_core_pkg;

    typedef enum logic [2:0] {
        S_INIT,   // clearing neuron memory after reset
        S_IDLE,   // waiting for a step strobe
        S_RD,     // memory read issued for current index
        S_UPD,    // state available, update computed and written
        S_EMIT,   // offering a fired index downstream
        S_DONE    // end-of-step pulse
    } core_state_e;

endpackage

// File: rtl/lif_state_ram.sv
`timescale 1ns/1ps
// Module: lif_state_ram
// Single-port-per-direction neuron state memory: one synchronous write port
// and one synchronous read port with a one-cycle read latency.
// Assumes the controller never reads and writes the same word in one cycle.
module lif_state_ram #(
    parameter int DEPTH = 256,
    parameter int DW    = 33,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [DW-1:0] wd,
    input  logic          re,
    input  logic [AW-1:0] ra,
    output logic [DW-1:0] rd
);

    logic [DW-1:0] mem [DEPTH];

    // Store a word when the write enable is high.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[wa] <= wd;
        end
    end

    // Register the addressed word when the read enable is high.
    always_ff @(posedge clk) begin
        if (re) begin
            rd <= mem[ra];
        end
    end

endmodule

// File: rtl/lif_syn_accum.sv
`timescale 1ns/1ps
// Module: lif_syn_accum
// Adds the signed weights of all active input lines for one neuron.
// Purely combinational; the sum width is sized so it cannot overflow.
module lif_syn_accum #(
    parameter int NUM_IN = 4,
    parameter int W_W    = 8,
    localparam int SUM_W = W_W + $clog2(NUM_IN) + 1
) (
    input  logic [NUM_IN-1:0]       in_mask,
    input  logic [NUM_IN*W_W-1:0]   wt_row,
    output logic signed [SUM_W-1:0] syn_sum
);

    logic signed [SUM_W-1:0] term [NUM_IN];

    // One gated, sign-extended term per input line.
    for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_term
        assign term[gi] = in_mask[gi] ? SUM_W'($signed(wt_row[gi*W_W +: W_W]))
                                      : '0;
    end

    // Sum all gated terms.
    always_comb begin
        logic signed [SUM_W-1:0] acc;
        acc = '0;
        for (int i = 0; i < NUM_IN; i++) begin
            acc = acc + term[i];
        end
        syn_sum = acc;
    end

endmodule

// File: rtl/lif_update.sv
`timescale 1ns/1ps
// Module: lif_update
// Combinational neuron update: integrate with saturation, leak down to a
// floor, refractory-gated threshold compare and post-fire reset.
// Assumes the synaptic sum already holds only the active weights.
module lif_update #(
    parameter int POT_W  = 16,
    parameter int STEP_W = 16,
    parameter int SUM_W  = 11
) (
    input  logic signed [POT_W-1:0]  pot_in,
    input  logic [STEP_W-1:0]        last_in,
    input  logic                     ever_in,
    input  logic signed [SUM_W-1:0]  syn_sum,
    input  logic [STEP_W-1:0]        cur_step,
    input  logic signed [POT_W-1:0]  cfg_threshold,
    input  logic [POT_W-1:0]         cfg_leak,
    input  logic signed [POT_W-1:0]  cfg_floor,
    input  logic [STEP_W-1:0]        cfg_refractory,
    input  logic                     cfg_reset_mode,
    input  logic signed [POT_W-1:0]  cfg_reset_val,
    input  logic [POT_W-1:0]         cfg_sub_amt,
    output logic                     fire,
    output logic signed [POT_W-1:0]  pot_out
);

    localparam int EXT_W = ((POT_W > SUM_W) ? POT_W : SUM_W) + 3;
    localparam logic signed [EXT_W-1:0] MAX_X =
        {{(EXT_W-POT_W+1){1'b0}}, {(POT_W-1){1'b1}}};
    localparam logic signed [EXT_W-1:0] MIN_X =
        {{(EXT_W-POT_W+1){1'b1}}, {(POT_W-1){1'b0}}};

    logic signed [EXT_W-1:0] raw_x, int_x, lk_x, v_x, sb_x, sbs_x;
    logic signed [EXT_W-1:0] leak_x, floor_x, thr_x, sub_x;
    logic [STEP_W-1:0]       elapsed;
    logic                    refr_ok;

    // Widen all operands to a common signed width.
    always_comb begin
        leak_x  = EXT_W'(cfg_leak);
        sub_x   = EXT_W'(cfg_sub_amt);
        floor_x = EXT_W'(cfg_floor);
        thr_x   = EXT_W'(cfg_threshold);
    end

    // Integrate the synaptic sum and clamp to the potential range.
    always_comb begin
        raw_x = EXT_W'(pot_in) + EXT_W'(syn_sum);
        if (raw_x > MAX_X) begin
            int_x = MAX_X;
        end else if (raw_x < MIN_X) begin
            int_x = MIN_X;
        end else begin
            int_x = raw_x;
        end
    end

    // Apply the leak without letting it cross the floor.
    always_comb begin
        lk_x = int_x - leak_x;
        if (lk_x < floor_x) begin
            v_x = (int_x < floor_x) ? int_x : floor_x;
        end else begin
            v_x = lk_x;
        end
    end

    // Threshold compare gated by the refractory window.
    always_comb begin
        elapsed = cur_step - last_in;
        refr_ok = !ever_in || (elapsed > cfg_refractory);
        fire    = (v_x > thr_x) && refr_ok;
    end

    // Select the stored potential: plain update or one of two reset modes.
    always_comb begin
        sb_x  = v_x - sub_x;
        sbs_x = (sb_x < MIN_X) ? MIN_X : sb_x;
        if (!fire) begin
            pot_out = POT_W'(v_x);
        end else if (cfg_reset_mode) begin
            pot_out = POT_W'(sbs_x);
        end else begin
            pot_out = cfg_reset_val;
        end
    end

endmodule

// File: rtl/lif_neuron_core.sv
`timescale 1ns/1ps
// Module: lif_neuron_core
// Sweeps every neuron once per time step through one shared update datapath.
// Per neuron: read state (1 cycle), update and write back (1 cycle), and
// offer the index downstream if it fired (holds until accepted).
// Assumes wt_row answers wt_addr combinationally and stays valid while
// wt_addr is stable. N_NEURONS must be a power of two of at least 2.
module lif_neuron_core
    import lif_core_pkg::*;
#(
    parameter int N_NEURONS = 256,
    parameter int NUM_IN    = 4,
    parameter int W_W       = 8,
    parameter int POT_W     = 16,
    parameter int STEP_W    = 16,
    localparam int IDX_W    = $clog2(N_NEURONS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      step_start,
    input  logic [NUM_IN-1:0]         in_spike,
    output logic [IDX_W-1:0]          wt_addr,
    input  logic [NUM_IN*W_W-1:0]     wt_row,
    input  logic signed [POT_W-1:0]   cfg_threshold,
    input  logic [POT_W-1:0]          cfg_leak,
    input  logic signed [POT_W-1:0]   cfg_floor,
    input  logic [STEP_W-1:0]         cfg_refractory,
    input  logic                      cfg_reset_mode,
    input  logic signed [POT_W-1:0]   cfg_reset_val,
    input  logic [POT_W-1:0]          cfg_sub_amt,
    output logic                      fire_valid,
    input  logic                      fire_ready,
    output logic [IDX_W-1:0]          fire_idx,
    output logic                      step_done
);

    localparam int SUM_W = W_W + $clog2(NUM_IN) + 1;
    localparam int DW    = POT_W + STEP_W + 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_NEURONS - 1);

    core_state_e               state;
    logic [IDX_W-1:0]          idx;
    logic [STEP_W-1:0]         cur_step;
    logic [NUM_IN-1:0]         mask_q;

    logic                      mem_we, mem_re;
    logic [DW-1:0]             mem_wd, mem_rd;
    logic signed [POT_W-1:0]   rd_pot;
    logic [STEP_W-1:0]         rd_last;
    logic                      rd_ever;
    logic signed [SUM_W-1:0]   syn_sum;
    logic                      upd_fire;
    logic signed [POT_W-1:0]   upd_pot;
    logic                      at_last;

    assign at_last    = (idx == LAST_IDX);
    assign wt_addr    = idx;
    assign fire_idx   = idx;
    assign fire_valid = (state == S_EMIT);
    assign step_done  = (state == S_DONE);

    // Split the stored word into its fields.
    assign rd_pot  = mem_rd[POT_W-1:0];
    assign rd_last = mem_rd[POT_W +: STEP_W];
    assign rd_ever = mem_rd[DW-1];

    // Sweep controller: init clear, step accept, per-neuron walk and emit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_INIT;
            idx      <= '0;
            cur_step <= '0;
            mask_q   <= '0;
        end else begin
            case (state)
                S_INIT: begin
                    if (at_last) begin
                        idx   <= '0;
                        state <= S_IDLE;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                S_IDLE: begin
                    if (step_start) begin
                        mask_q   <= in_spike;
                        cur_step <= cur_step + 1'b1;
                        idx      <= '0;
                        state    <= S_RD;
                    end
                end
                S_RD: begin
                    state <= S_UPD;
                end
                S_UPD: begin
                    if (upd_fire) begin
                        state <= S_EMIT;
                    end else if (at_last) begin
                        state <= S_DONE;
                    end else begin
                        idx   <= idx + 1'b1;
                        state <= S_RD;
                    end
                end
                S_EMIT: begin
                    if (fire_ready) begin
                        if (at_last) begin
                            state <= S_DONE;
                        end else begin
                            idx   <= idx + 1'b1;
                            state <= S_RD;
                        end
                    end
                end
                S_DONE: begin
                    idx   <= '0;
                    state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Memory port control: clear during init, write back during update.
    always_comb begin
        mem_re = (state == S_RD);
        mem_we = (state == S_INIT) || (state == S_UPD);
        if (state == S_INIT) begin
            mem_wd = '0;
        end else begin
            mem_wd = {rd_ever | upd_fire,
                      upd_fire ? cur_step : rd_last,
                      upd_pot};
        end
    end

    lif_state_ram #(
        .DEPTH (N_NEURONS),
        .DW    (DW)
    ) i_state_ram (
        .clk (clk),
        .we  (mem_we),
        .wa  (idx),
        .wd  (mem_wd),
        .re  (mem_re),
        .ra  (idx),
        .rd  (mem_rd)
    );

    lif_syn_accum #(
        .NUM_IN (NUM_IN),
        .W_W    (W_W)
    ) i_syn_accum (
        .in_mask (mask_q),
        .wt_row  (wt_row),
        .syn_sum (syn_sum)
    );

    lif_update #(
        .POT_W  (POT_W),
        .STEP_W (STEP_W),
        .SUM_W  (SUM_W)
    ) i_update (
        .pot_in         (rd_pot),
        .last_in        (rd_last),
        .ever_in        (rd_ever),
        .syn_sum        (syn_sum),
        .cur_step       (cur_step),
        .cfg_threshold  (cfg_threshold),
        .cfg_leak       (cfg_leak),
        .cfg_floor      (cfg_floor),
        .cfg_refractory (cfg_refractory),
        .cfg_reset_mode (cfg_reset_mode),
        .cfg_reset_val  (cfg_reset_val),
        .cfg_sub_amt    (cfg_sub_amt),
        .fire           (upd_fire),
        .pot_out        (upd_pot)
    );

    // Ordering tracker: last index handed downstream within this sweep.
    logic [IDX_W-1:0] chk_last;
    logic             chk_any;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_any  <= 1'b0;
            chk_last <= '0;
        end else if (state == S_DONE) begin
            chk_any <= 1'b0;
        end else if (fire_valid && fire_ready) begin
            chk_any  <= 1'b1;
            chk_last <= fire_idx;
        end
    end

    // R7: fired indices rise strictly within one sweep.
    p_ascending_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fire_valid && chk_any |-> fire_idx > chk_last);

    // R7: a stalled offer stays put.
    p_hold_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fire_valid && !fire_ready |=> fire_valid && $stable(fire_idx));

    // R8: end-of-step indication lasts one cycle.
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        step_done |=> !step_done);

    // R9: a strobe during a sweep leaves the step number alone.
    p_strobe_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        step_start && (state != S_IDLE) |=> $stable(cur_step));

    // R5: an accepted strobe advances the step number by one.
    p_step_adv_r5: assert property (@(posedge clk) disable iff (!rst_n)
        step_start && (state == S_IDLE) |=> cur_step == $past(cur_step) + 1'b1);

    // R4: with non-negative input and a start at or above floor, no fall below it.
    p_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_UPD) && !upd_fire && (rd_pot >= cfg_floor) && (syn_sum >= 0)
        |-> upd_pot >= cfg_floor);

endmodule

// File: tb/test_lif_neuron_core.sv
`timescale 1ns/1ps
// Bench for lif_neuron_core: reference model of the potentials, a table of
// step vectors, then directed phases for init, strobe rejection,
// saturation, floor and refractory.
module test_lif_neuron_core;

    localparam int N   = 8;
    localparam int NI  = 4;
    localparam int WW  = 8;
    localparam int PW  = 16;
    localparam int SW  = 16;
    localparam int IW  = $clog2(N);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              step_start = 1'b0;
    logic [NI-1:0]     in_spike = '0;
    logic [IW-1:0]     wt_addr;
    logic [NI*WW-1:0]  wt_row;
    logic              fire_valid;
    logic              fire_ready = 1'b1;
    logic [IW-1:0]     fire_idx;
    logic              step_done;

    int thr = 20, leak = 1, flr = -10, refr = 2, rmode = 0, rval = -5, sub = 15;
    int wmode = 0;

    int n_chk = 0, n_fail = 0;
    int m_pot [N];
    int m_last [N];
    bit m_ever [N];
    int m_step = 0;
    int exp_idx [16];
    int exp_cnt;
    int got_idx [16];
    int got_cnt;
    int total_cyc = 0;

    always #2.5 clk = ~clk;

    lif_neuron_core #(
        .N_NEURONS (N), .NUM_IN (NI), .W_W (WW), .POT_W (PW), .STEP_W (SW)
    ) i_lif_neuron_core (
        .clk            (clk),
        .rst_n          (rst_n),
        .step_start     (step_start),
        .in_spike       (in_spike),
        .wt_addr        (wt_addr),
        .wt_row         (wt_row),
        .cfg_threshold  (PW'(thr)),
        .cfg_leak       (PW'(leak)),
        .cfg_floor      (PW'(flr)),
        .cfg_refractory (SW'(refr)),
        .cfg_reset_mode (rmode[0]),
        .cfg_reset_val  (PW'(rval)),
        .cfg_sub_amt    (PW'(sub)),
        .fire_valid     (fire_valid),
        .fire_ready     (fire_ready),
        .fire_idx       (fire_idx),
        .step_done      (step_done)
    );

    function automatic int wfun(int n, int i);
        case (wmode)
            0:       return ((n * 7 + i * 13) % 23) - 6;
            1:       return 127;
            default: return 0;
        endcase
    endfunction

    // Weight source answering the requested neuron index.
    always_comb begin
        for (int i = 0; i < NI; i++) begin
            wt_row[i*WW +: WW] = WW'(wfun(int'(wt_addr), i));
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int expv,
                         input string what);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    // Reference model of one step, from the requirements.
    task automatic model_step(input logic [NI-1:0] mask);
        m_step  = (m_step + 1) % 65536;
        exp_cnt = 0;
        for (int n = 0; n < N; n++) begin
            int s, iv, lk, v, el, nv;
            bit f;
            s = 0;
            for (int i = 0; i < NI; i++) if (mask[i]) s += wfun(n, i);
            iv = m_pot[n] + s;
            if (iv > 32767) iv = 32767;
            if (iv < -32768) iv = -32768;
            lk = iv - leak;
            if (lk < flr) v = (iv < flr) ? iv : flr;
            else v = lk;
            el = ((m_step - m_last[n]) % 65536 + 65536) % 65536;
            f = (v > thr) && (!m_ever[n] || el > refr);
            if (f) begin
                if (rmode != 0) begin
                    nv = v - sub;
                    if (nv < -32768) nv = -32768;
                end else begin
                    nv = rval;
                end
                m_last[n] = m_step;
                m_ever[n] = 1'b1;
                exp_idx[exp_cnt] = n;
                exp_cnt++;
            end else begin
                nv = v;
            end
            m_pot[n] = nv;
        end
    endtask

    // Run one step, collect the fire stream and compare with the model.
    task automatic run_step(input logic [NI-1:0] mask, input bit stall,
                            input bit extra, input string tag);
        bit done;
        model_step(mask);
        @(negedge clk);
        in_spike   = mask;
        step_start = 1'b1;
        @(negedge clk);
        step_start = 1'b0;
        got_cnt = 0;
        done    = 1'b0;
        for (int cyc = 0; cyc < 400 && !done; cyc++) begin
            fire_ready = stall ? (cyc % 3 != 0) : 1'b1;
            step_start = extra && (cyc == 4);
            if (fire_valid && fire_ready) begin
                if (got_cnt < 16) got_idx[got_cnt] = int'(fire_idx);
                got_cnt++;
            end
            if (step_done) done = 1'b1;
            @(negedge clk);
        end
        step_start = 1'b0;
        fire_ready = 1'b1;
        check(done, "R8", int'(done), 1, "step_done seen");
        check(step_done == 1'b0, "R8", int'(step_done), 0, "step_done one cycle");
        check(got_cnt == exp_cnt, tag, got_cnt, exp_cnt, "fire count");
        for (int k = 0; k < exp_cnt && k < got_cnt; k++) begin
            check(got_idx[k] == exp_idx[k], "R7", got_idx[k], exp_idx[k], "fire index order");
        end
    endtask

    // Step vectors: {mask[3:0], stall, reset_mode}.
    localparam int NROWS = 10;
    localparam logic [5:0] TABLE [NROWS] = '{
        6'b1111_0_0, 6'b1010_1_0, 6'b0101_0_0, 6'b1111_1_0, 6'b0011_0_0,
        6'b1100_0_1, 6'b1111_1_1, 6'b0000_0_1, 6'b1001_1_1, 6'b1111_0_1
    };

    initial begin
        for (int n = 0; n < N; n++) begin
            m_pot[n] = 0; m_last[n] = 0; m_ever[n] = 1'b0;
        end
        repeat (3) @(negedge clk);
        check(fire_valid == 1'b0, "R1", int'(fire_valid), 0, "fire_valid in reset");
        check(step_done == 1'b0, "R1", int'(step_done), 0, "step_done in reset");
        rst_n = 1'b1;
        // Strobe during the clear must be ignored (R1).
        @(negedge clk);
        step_start = 1'b1;
        @(negedge clk);
        step_start = 1'b0;
        repeat (N + 4) @(negedge clk);
        check(step_done == 1'b0 && fire_valid == 1'b0, "R1", int'(step_done), 0,
              "idle after clear");

        // R1: cleared state -> zero potential: threshold 0 none, then -1 all.
        wmode = 2; leak = 0; thr = 0;
        run_step('0, 1'b0, 1'b0, "R1");
        check(got_cnt == 0, "R1", got_cnt, 0, "no fire at threshold 0");
        thr = -1;
        run_step('0, 1'b0, 1'b0, "R1");
        check(got_cnt == N, "R1", got_cnt, N, "all fire at threshold -1");

        // Table walk: integration, leak, threshold, both reset modes (R2, R6).
        wmode = 0; thr = 20; leak = 1; flr = -10; refr = 2; rval = -5; sub = 15;
        for (int r = 0; r < NROWS; r++) begin
            rmode = int'(TABLE[r][0]);
            run_step(TABLE[r][5:2], TABLE[r][1], 1'b0, rmode != 0 ? "R6" : "R2");
        end

        // R9: extra strobe mid-sweep has no effect.
        run_step(4'b1111, 1'b0, 1'b1, "R9");
        begin
            int extra_done;
            extra_done = 0;
            for (int c = 0; c < 12; c++) begin
                if (step_done || fire_valid) extra_done++;
                @(negedge clk);
            end
            check(extra_done == 0, "R9", extra_done, 0, "no activity after ignored strobe");
        end
        run_step(4'b0110, 1'b1, 1'b0, "R9");

        // R3: saturate at the top, then read it back through firing.
        wmode = 1; thr = 32767; leak = 0; refr = 0; rmode = 1; sub = 100;
        for (int s = 0; s < 70; s++) run_step(4'b1111, 1'b0, 1'b0, "R3");
        wmode = 2; thr = 32000;
        run_step('0, 1'b0, 1'b0, "R3");
        check(got_cnt == N, "R3", got_cnt, N, "saturated potentials fire");
        run_step('0, 1'b1, 1'b0, "R6");
        check(got_cnt == N, "R6", got_cnt, N, "subtract mode keeps above threshold");

        // R4: leak stops at the floor.
        thr = 32767; leak = 5000; flr = -100;
        for (int s = 0; s < 10; s++) run_step('0, 1'b0, 1'b0, "R4");
        leak = 0; thr = -100;
        run_step('0, 1'b0, 1'b0, "R4");
        check(got_cnt == 0, "R4", got_cnt, 0, "floor not above -100");
        thr = -101;
        run_step('0, 1'b0, 1'b0, "R4");
        check(got_cnt == N, "R4", got_cnt, N, "floor reached -100");

        // R5: refractory window of 3 steps.
        thr = 32767; refr = 3; rmode = 0; rval = 0;
        for (int s = 0; s < 4; s++) run_step('0, 1'b0, 1'b0, "R5");
        thr = -1000;
        run_step('0, 1'b0, 1'b0, "R5");
        check(got_cnt == N, "R5", got_cnt, N, "fire after window");
        for (int s = 0; s < 3; s++) begin
            run_step('0, 1'b0, 1'b0, "R5");
            check(got_cnt == 0, "R5", got_cnt, 0, "blocked inside window");
        end
        run_step('0, 1'b1, 1'b0, "R5");
        check(got_cnt == N, "R5", got_cnt, N, "fire when window elapsed");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung sweep ends the run as a failure.
    always @(posedge clk) begin
        total_cyc++;
        if (total_cyc == 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL R8 watchdog: actual %0d cycles expected fewer", total_cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule